// File: doc/BRIEF.md
# Pipeline hazard and forwarding control

This block steers a five-stage in-order integer pipeline through its data and control hazards. It looks at the register specifiers and a few control bits in the decode, execute, memory and write-back pipeline registers, and at the branch-compare result formed in decode. It is purely combinational. Its outputs drive four things:

- the select lines of the two execute-stage operand multiplexers;
- two decode-stage bypass selects;
- the hold enables for the program counter and the fetch/decode register;
- the bubble and flush controls.

The register file commits on the rising clock edge. A decode-stage read of the register being written in that same cycle would therefore return the old value. The decode bypass selects pick the write-back data in that case.

When a load in execute targets a register that the decode instruction reads, the unit asks for one stall cycle. The stall holds fetch and decode and injects a bubble with every control bit cleared. A taken branch resolves in decode and flushes the fetch/decode register to the all-zero nop, which costs one cycle. A stall takes precedence over a branch: the branch stays in decode and is evaluated again once the stall clears.

All outputs are plain control pins with no handshake. They are valid in the same cycle as the inputs they are derived from. The clock and reset drive only the embedded property checks.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: An execute operand select is 2'b10 (memory-stage result) when the memory-stage instruction writes a register, its destination is nonzero, and that destination equals the operand's source. Operand A uses the execute Rs and operand B uses the execute Rt.
- R2: An execute operand select is 2'b01 (write-back result) when R1 does not apply, the write-back instruction writes a register, its destination is nonzero, and that destination equals the operand's source.
- R3: When both the memory-stage and the write-back-stage destinations match an operand's source, the select is 2'b10.
- R4: In every other case the operand select is 2'b00 (register file value). This includes any source of register 0 and any stage whose write enable is low.
- R5: A decode bypass select (A for decode Rs, B for decode Rt) is 1 exactly when the write-back instruction writes a register, its destination is nonzero, and that destination equals the decode source; otherwise it is 0.
- R6: When the execute instruction is a load and its Rt equals the decode Rs or the decode Rt, pc_hold, ifid_hold and idex_bubble are all 1.
- R7: A taken branch (branch flag and compare result both 1) with no stall under R6 raises if_flush and leaves the holds and the bubble at 0.
- R8: When R6 and a taken branch coincide, if_flush is 0 and the stall of R6 is applied.
- R9: With neither a stall nor a taken branch, pc_hold, ifid_hold, idex_bubble and if_flush are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rst_n | input | 1 | Active-low reset, disables the property checks |
| ifid_rs | input | REG_W | Decode-stage first source register |
| ifid_rt | input | REG_W | Decode-stage second source register |
| idex_rs | input | REG_W | Execute-stage first source register |
| idex_rt | input | REG_W | Execute-stage second source register (load destination) |
| idex_mem_read | input | 1 | Execute-stage instruction is a load |
| exmem_rd | input | REG_W | Memory-stage destination register |
| exmem_reg_write | input | 1 | Memory-stage instruction writes a register |
| memwb_rd | input | REG_W | Write-back destination register |
| memwb_reg_write | input | 1 | Write-back instruction writes a register |
| id_branch | input | 1 | Decode-stage instruction is a conditional branch |
| id_cmp_true | input | 1 | Decode-stage branch compare result |
| fwd_a_sel | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 write-back |
| fwd_b_sel | output | 2 | Operand B source, same encoding |
| id_byp_a | output | 1 | Decode Rs read takes write-back data |
| id_byp_b | output | 1 | Decode Rt read takes write-back data |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| idex_bubble | output | 1 | Zero all control bits entering execute |
| if_flush | output | 1 | Zero the instruction in the fetch/decode register |

## Verification
The bench sweeps every specifier combination of a three-bit register space against all write-enable, load and branch flag settings. These are the corner cases it targets:

- **Both forwarding sources match at once.** A unit with the wrong priority would feed a stale write-back value instead of the newer memory-stage result.
- **Register 0 as a destination.** A unit that forwards it would hand a nonzero value to a read that must see zero.
- **A load whose Rt matches only the decode Rt.** A stall unit that checks only Rs would let the dependent instruction read the value before the load delivers it.
- **A stall and a taken branch in the same cycle.** A unit that flushed there would discard the held branch, so its target would be lost.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Operand source codes for the execute-stage multiplexers
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       sel
);
  import hz_pkg::*;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic mem_hit, wb_hit;
  assign mem_hit = mem_we && (mem_rd != ZERO_REG) && (mem_rd == src);
  assign wb_hit  = wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src);

  always_comb begin
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end

  AST_ZERO_NOFWD: assert property (@(posedge clk) disable iff (!rst_n) (src == ZERO_REG) |-> (sel == 2'b00)); // R4
  AST_MEM_PRIO: assert property (@(posedge clk) disable iff (!rst_n) (mem_we && mem_rd == src && src != ZERO_REG) |-> (sel == 2'b10)); // R3
  AST_NO_WE_NOFWD: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we && !wb_we) |-> (sel == 2'b00)); // R4
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) sel != 2'b11); // R2
endmodule

// File: rtl/hz_id_bypass.sv
module hz_id_bypass #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic             byp
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  assign byp = wb_we && (wb_rd != ZERO_REG) && (wb_rd == src);

  AST_BYP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (src == ZERO_REG) |-> !byp); // R5
  AST_BYP_NOWE: assert property (@(posedge clk) disable iff (!rst_n) !wb_we |-> !byp); // R5
endmodule

// File: rtl/hz_stall_flush.sv
module hz_stall_flush #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ifid_rs,
  input  logic [REG_W-1:0] ifid_rt,
  input  logic [REG_W-1:0] idex_rt,
  input  logic             idex_mem_read,
  input  logic             id_branch,
  input  logic             id_cmp_true,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble,
  output logic             if_flush
);
  logic load_use, br_taken;

  assign load_use = idex_mem_read && ((idex_rt == ifid_rs) || (idex_rt == ifid_rt));
  assign br_taken = id_branch && id_cmp_true;

  assign pc_hold     = load_use;
  assign ifid_hold   = load_use;
  assign idex_bubble = load_use;
  // A held branch is re-evaluated once the stall clears
  assign if_flush    = br_taken && !load_use;

  AST_FLUSH_VS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) if_flush |-> !pc_hold && !ifid_hold); // R8
  AST_HOLD_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) pc_hold |-> ifid_hold && idex_bubble); // R6
  AST_NO_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n) !idex_mem_read |-> !idex_bubble); // R9
  AST_FLUSH_NEEDS_BR: assert property (@(posedge clk) disable iff (!rst_n) if_flush |-> id_branch && id_cmp_true); // R7
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int REG_W   = 5,
  parameter int NUM_OPS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ifid_rs,
  input  logic [REG_W-1:0] ifid_rt,
  input  logic [REG_W-1:0] idex_rs,
  input  logic [REG_W-1:0] idex_rt,
  input  logic             idex_mem_read,
  input  logic [REG_W-1:0] exmem_rd,
  input  logic             exmem_reg_write,
  input  logic [REG_W-1:0] memwb_rd,
  input  logic             memwb_reg_write,
  input  logic             id_branch,
  input  logic             id_cmp_true,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             id_byp_a,
  output logic             id_byp_b,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble,
  output logic             if_flush
);
  logic [REG_W-1:0] ex_src [NUM_OPS];
  logic [REG_W-1:0] id_src [NUM_OPS];
  logic [1:0]       ex_sel [NUM_OPS];
  logic             id_byp [NUM_OPS];

  assign ex_src[0] = idex_rs;
  assign ex_src[1] = idex_rt;
  assign id_src[0] = ifid_rs;
  assign id_src[1] = ifid_rt;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hz_fwd_sel #(.REG_W(REG_W)) u_fwd (
      .clk(clk), .rst_n(rst_n), .src(ex_src[g]),
      .mem_rd(exmem_rd), .mem_we(exmem_reg_write),
      .wb_rd(memwb_rd), .wb_we(memwb_reg_write),
      .sel(ex_sel[g])
    );
    hz_id_bypass #(.REG_W(REG_W)) u_byp (
      .clk(clk), .rst_n(rst_n), .src(id_src[g]),
      .wb_rd(memwb_rd), .wb_we(memwb_reg_write),
      .byp(id_byp[g])
    );
  end

  assign fwd_a_sel = ex_sel[0];
  assign fwd_b_sel = ex_sel[1];
  assign id_byp_a  = id_byp[0];
  assign id_byp_b  = id_byp[1];

  hz_stall_flush #(.REG_W(REG_W)) u_sf (
    .clk(clk), .rst_n(rst_n),
    .ifid_rs(ifid_rs), .ifid_rt(ifid_rt), .idex_rt(idex_rt),
    .idex_mem_read(idex_mem_read), .id_branch(id_branch), .id_cmp_true(id_cmp_true),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble), .if_flush(if_flush)
  );

  AST_STALL_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (idex_mem_read && idex_rt == ifid_rs) |-> pc_hold && !if_flush); // R6
endmodule

// File: tb/sim_pipe_hazard_ctrl.sv
module sim_pipe_hazard_ctrl;
  localparam int RW = 3;
  localparam int MAX_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [RW-1:0] ifid_rs = '0, ifid_rt = '0, idex_rs = '0, idex_rt = '0;
  logic [RW-1:0] exmem_rd = '0, memwb_rd = '0;
  logic idex_mem_read = 0, exmem_reg_write = 0, memwb_reg_write = 0;
  logic id_branch = 0, id_cmp_true = 0;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic id_byp_a, id_byp_b, pc_hold, ifid_hold, idex_bubble, if_flush;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  pipe_hazard_ctrl #(.REG_W(RW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_fwd(int s, int mr, int mw, int wr, int ww);
    if (mw != 0 && mr != 0 && mr == s) return 2;
    if (ww != 0 && wr != 0 && wr == s) return 1;
    return 0;
  endfunction

  function automatic string fwd_tag(int s, int mr, int mw, int wr, int ww);
    int e;
    e = exp_fwd(s, mr, mw, wr, ww);
    if (e == 2) return (ww != 0 && wr == mr) ? "R3" : "R1";
    if (e == 1) return "R2";
    return "R4";
  endfunction

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    // reset state with idle inputs: R9
    chk("R9 reset hold", pc_hold, 0);
    chk("R9 reset flush", if_flush, 0);
    chk("R4 reset fwd", fwd_a_sel, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // forwarding sweep: R1 R2 R3 R4
    for (int s = 0; s < 8; s++)
      for (int mr = 0; mr < 8; mr++)
        for (int wr = 0; wr < 8; wr++)
          for (int f = 0; f < 4; f++) begin
            @(negedge clk);
            idex_rs = RW'(s); idex_rt = RW'(s ^ 5);
            exmem_rd = RW'(mr); memwb_rd = RW'(wr);
            exmem_reg_write = f[0]; memwb_reg_write = f[1];
            #1;
            chk(fwd_tag(s, mr, f[0], wr, f[1]), fwd_a_sel, exp_fwd(s, mr, f[0], wr, f[1]));
            chk(fwd_tag(s ^ 5, mr, f[0], wr, f[1]), fwd_b_sel, exp_fwd(s ^ 5, mr, f[0], wr, f[1]));
          end

    // decode bypass, stall and flush sweep: R5 R6 R7 R8 R9
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int t = 0; t < 8; t++)
          for (int w = 0; w < 8; w++)
            for (int f = 0; f < 16; f++) begin
              bit ld, st, br;
              ifid_rs = RW'(a); ifid_rt = RW'(b); idex_rt = RW'(t); memwb_rd = RW'(w);
              idex_mem_read = f[0]; id_branch = f[1]; id_cmp_true = f[2]; memwb_reg_write = f[3];
              #1;
              ld = f[0] && (t == a || t == b);
              br = f[1] && f[2];
              st = ld;
              chk("R5 byp_a", id_byp_a, int'(f[3] && w != 0 && w == a));
              chk("R5 byp_b", id_byp_b, int'(f[3] && w != 0 && w == b));
              chk(st ? "R6 pc_hold" : "R9 pc_hold", pc_hold, int'(st));
              chk(st ? "R6 ifid_hold" : "R9 ifid_hold", ifid_hold, int'(st));
              chk(st ? "R6 bubble" : "R9 bubble", idex_bubble, int'(st));
              chk(br ? (st ? "R8 flush" : "R7 flush") : "R9 flush", if_flush, int'(br && !st));
            end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule